// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block derives the internal horizontal and vertical blanking pulses of a display pipeline from two raw timing strobes: a horizontal flyback level and a vertical blanking level. It runs in the pixel-clock domain. A pixel counter measures each line from one flyback rising edge to the next. Using a selected pixels-per-line figure, it predicts where the next flyback will fall, so horizontal blanking can open a programmed number of pixels before the flyback arrives. Horizontal blanking always closes on the falling edge of the flyback.

Vertical blanking opens on a rising vertical strobe and stays open for a programmed number of lines. Lines are counted on flyback rising edges. A sync-valid flag tells downstream overlay logic that both strobes are present and recent. The flag drops if either strobe stops arriving.

Settings are written into a holding register through a single-cycle write strobe. They are copied into the working set only when a vertical strobe rises, so a frame never runs on a mix of old and new settings.

Top module: `scan_blank_gen`

## Requirements
- R1: After reset all three outputs are low, and the working settings are: vertical length 3, advance 0, pixels-per-line code 0, both enables set, vertical timeout 0.
- R2: The pixels-per-line count is 704 + 64 × code, where code is the 3-bit `cfg_ppl_i` value, giving 704 to 1152 in steps of 64.
- R3: `hblank_o` rises at the first clock edge that samples `hfly_i` high after it was low, stays high while `hfly_i` stays high, and falls at the first edge that samples `hfly_i` low.
- R4: Once a flyback rising edge has been seen, `hblank_o` also rises at the edge where the count of clocks since the last flyback rising edge reaches (pixels per line − advance). The advance is `cfg_adv_i`, and values above 64 act as 64.
- R5: Before the first flyback rising edge after reset, `hblank_o` never rises, however many clocks pass.
- R6: `vblank_o` rises at the first edge that samples `vstrb_i` high after it was low. It falls at the edge that samples the N-th flyback rising edge after that, where N is `cfg_vlen_i` (0 to 127) and values below 3 act as 3.
- R7: While the working horizontal enable is 0, `hblank_o` stays low. While the working vertical enable is 0, `vblank_o` stays low.
- R8: A write (`cfg_wr_i` high for one cycle) changes no output behaviour until the next vertical strobe rising edge, which loads it into the working settings.
- R9: `sync_ok_o` is high only after both a flyback rising edge and a vertical strobe rising edge have been seen and neither has timed out.
- R10: `sync_ok_o` falls 2304 clocks after the last flyback rising edge if no new one arrives, and returns at the next flyback rising edge.
- R11: With a nonzero working vertical timeout T (`cfg_vto_i`, 11 bits), `sync_ok_o` falls at the T-th flyback rising edge after the last vertical strobe rising edge. A value of 0 disables this timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hfly_i | input | 1 | Horizontal flyback level |
| vstrb_i | input | 1 | Vertical blanking strobe level |
| cfg_wr_i | input | 1 | Write strobe for the holding settings |
| cfg_vlen_i | input | 7 | Vertical blanking length in lines |
| cfg_adv_i | input | 7 | Horizontal blanking advance in pixels |
| cfg_ppl_i | input | 3 | Pixels-per-line code |
| cfg_hen_i | input | 1 | Horizontal blanking enable |
| cfg_ven_i | input | 1 | Vertical blanking enable |
| cfg_vto_i | input | 11 | Vertical strobe timeout in lines, 0 disables |
| hblank_o | output | 1 | Internal horizontal blanking |
| vblank_o | output | 1 | Internal vertical blanking |
| sync_ok_o | output | 1 | Both timing strobes present |

## Verification
The early-start prediction is tried with four pairs of pixels-per-line code and advance, including an advance above the clamp. Each pair is checked on the cycle just before and just after the expected opening, so an off-by-one in the count, the subtraction or the code decode shows up directly. Vertical length is tried at its default, below the minimum, at a middle value and at the top value of 127, which separates the clamp from the line counting. The enable and deferred-write cases flip one setting at a time and watch the output on either side of the loading vertical strobe. The two sync timeouts are sampled on the exact cycles around expiry.

// File: rtl/bg_pkg.sv
package bg_pkg;

  localparam int LEN_W     = 7;
  localparam int ADV_W     = 7;
  localparam int CODE_W    = 3;
  localparam int VTO_W     = 11;
  localparam int CNT_W     = 12;

  localparam int PPL_BASE  = 704;
  localparam int PPL_STEP  = 64;
  localparam int ADV_MAX   = 64;
  localparam int VLEN_MIN  = 3;

  // longest line, doubled, is the flyback silence limit
  localparam int H_TMO_CLKS = 2 * (PPL_BASE + PPL_STEP * ((1 << CODE_W) - 1));

  typedef struct packed {
    logic [LEN_W-1:0]  vlen;
    logic [ADV_W-1:0]  adv;
    logic [CODE_W-1:0] code;
    logic              h_en;
    logic              v_en;
    logic [VTO_W-1:0]  vto;
  } blank_cfg_t;

  localparam blank_cfg_t CFG_RST = '{
    vlen: LEN_W'(VLEN_MIN),
    adv:  '0,
    code: '0,
    h_en: 1'b1,
    v_en: 1'b1,
    vto:  '0
  };

  function automatic logic [CNT_W-1:0] ppl_of(logic [CODE_W-1:0] code);
    return CNT_W'(PPL_BASE + PPL_STEP * int'(code));
  endfunction

  function automatic blank_cfg_t clamp_cfg(blank_cfg_t c);
    blank_cfg_t r;
    r = c;
    if (c.vlen < LEN_W'(VLEN_MIN)) r.vlen = LEN_W'(VLEN_MIN);
    if (c.adv > ADV_W'(ADV_MAX))   r.adv  = ADV_W'(ADV_MAX);
    return r;
  endfunction

endpackage

// File: rtl/bg_cfg.sv
module bg_cfg
  import bg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  blank_cfg_t wr_cfg,
  input  logic       v_start,
  output blank_cfg_t act_cfg
);

  blank_cfg_t hold_q, hold_d;
  blank_cfg_t act_q, act_d;

  always_comb begin
    hold_d = hold_q;
    act_d  = act_q;
    if (wr_en)   hold_d = clamp_cfg(wr_cfg);
    if (v_start) act_d  = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= CFG_RST;
      act_q  <= CFG_RST;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  assign act_cfg = act_q;

endmodule

// File: rtl/bg_hchan.sv
module bg_hchan
  import bg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_rise,
  input  logic              h_fall,
  input  logic [CODE_W-1:0] code,
  input  logic [ADV_W-1:0]  adv,
  input  logic              h_en,
  output logic              hblank
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] trig;
  logic             seen_q, seen_d;
  logic             hb_q, hb_d;

  assign trig = ppl_of(code) - CNT_W'(adv);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q | h_rise;
    hb_d   = hb_q;
    if (h_rise)                cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);

    if (h_rise)                        hb_d = 1'b1;
    else if (h_fall)                   hb_d = 1'b0;
    else if (seen_q && cnt_d == trig)  hb_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      hb_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      hb_q   <= hb_d;
    end
  end

  assign hblank = hb_q & h_en;

endmodule

// File: rtl/bg_vchan.sv
module bg_vchan
  import bg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_rise,
  input  logic             v_start,
  input  logic [LEN_W-1:0] vlen,
  input  logic             v_en,
  output logic             vblank
);

  logic [LEN_W-1:0] line_q, line_d;
  logic             vb_q, vb_d;
  logic             line_ce;

  assign line_ce = vb_q & h_rise;

  always_comb begin
    line_d = line_q;
    vb_d   = vb_q;
    if (v_start) begin
      line_d = '0;
      vb_d   = 1'b1;
    end else if (line_ce) begin
      line_d = line_q + LEN_W'(1);
      if (line_d == vlen) vb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      vb_q   <= 1'b0;
    end else begin
      line_q <= line_d;
      vb_q   <= vb_d;
    end
  end

  assign vblank = vb_q & v_en;

endmodule

// File: rtl/bg_sync_mon.sv
module bg_sync_mon
  import bg_pkg::*;
#(
  parameter int TMO_CLKS = H_TMO_CLKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_rise,
  input  logic             v_start,
  input  logic [VTO_W-1:0] vto,
  output logic             sync_ok
);

  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(TMO_CLKS);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(TMO_CLKS - 1);
  localparam logic [VTO_W-1:0] LN_MAX   = '1;

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             h_ok_q, h_ok_d;
  logic [VTO_W-1:0] ln_q, ln_d;
  logic             v_ok_q, v_ok_d;

  always_comb begin
    gap_d  = gap_q;
    h_ok_d = h_ok_q;
    if (h_rise) begin
      gap_d  = '0;
      h_ok_d = 1'b1;
    end else if (gap_q != GAP_END) begin
      gap_d = gap_q + CNT_W'(1);
      if (gap_q == GAP_LAST) h_ok_d = 1'b0;
    end
  end

  always_comb begin
    ln_d   = ln_q;
    v_ok_d = v_ok_q;
    if (v_start) begin
      ln_d   = '0;
      v_ok_d = 1'b1;
    end else if (h_rise && ln_q != LN_MAX) begin
      ln_d = ln_q + VTO_W'(1);
      if (vto != '0 && ln_d == vto) v_ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      h_ok_q <= 1'b0;
      ln_q   <= '0;
      v_ok_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      h_ok_q <= h_ok_d;
      ln_q   <= ln_d;
      v_ok_q <= v_ok_d;
    end
  end

  assign sync_ok = h_ok_q & v_ok_q;

endmodule

// File: rtl/scan_blank_gen.sv
module scan_blank_gen
  import bg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hfly_i,
  input  logic              vstrb_i,
  input  logic              cfg_wr_i,
  input  logic [LEN_W-1:0]  cfg_vlen_i,
  input  logic [ADV_W-1:0]  cfg_adv_i,
  input  logic [CODE_W-1:0] cfg_ppl_i,
  input  logic              cfg_hen_i,
  input  logic              cfg_ven_i,
  input  logic [VTO_W-1:0]  cfg_vto_i,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              sync_ok_o
);

  logic       hfly_q;
  logic       vst_q;
  logic       h_rise, h_fall, v_start;
  blank_cfg_t wr_cfg;
  blank_cfg_t act_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hfly_q <= 1'b0;
      vst_q  <= 1'b0;
    end else begin
      hfly_q <= hfly_i;
      vst_q  <= vstrb_i;
    end
  end

  assign h_rise  =  hfly_i & ~hfly_q;
  assign h_fall  = ~hfly_i &  hfly_q;
  assign v_start =  vstrb_i & ~vst_q;

  assign wr_cfg = '{
    vlen: cfg_vlen_i,
    adv:  cfg_adv_i,
    code: cfg_ppl_i,
    h_en: cfg_hen_i,
    v_en: cfg_ven_i,
    vto:  cfg_vto_i
  };

  bg_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_i),
    .wr_cfg  (wr_cfg),
    .v_start (v_start),
    .act_cfg (act_cfg)
  );

  bg_hchan u_hchan (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_rise (h_rise),
    .h_fall (h_fall),
    .code   (act_cfg.code),
    .adv    (act_cfg.adv),
    .h_en   (act_cfg.h_en),
    .hblank (hblank_o)
  );

  bg_vchan u_vchan (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_rise  (h_rise),
    .v_start (v_start),
    .vlen    (act_cfg.vlen),
    .v_en    (act_cfg.v_en),
    .vblank  (vblank_o)
  );

  bg_sync_mon #(
    .TMO_CLKS (H_TMO_CLKS)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_rise  (h_rise),
    .v_start (v_start),
    .vto     (act_cfg.vto),
    .sync_ok (sync_ok_o)
  );

endmodule

// File: rtl/bg_chk.sv
module bg_chk
  import bg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hblank,
  input logic       vblank,
  input logic       sync_ok,
  input logic       hfly_q,
  input logic       vst_q,
  input blank_cfg_t act
);

  // R3
  hblank_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hblank) && $stable(act.h_en) |-> $fell(hfly_q));

  // R3
  hblank_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hfly_q && act.h_en |-> hblank);

  // R6
  vblank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> $rose(vst_q));

  // R6
  vblank_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> $rose(hfly_q) || $rose(vst_q));

  // R9
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $rose(hfly_q) || $rose(vst_q));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(vst_q) |-> $stable(act));

  // R4
  adv_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.adv <= ADV_W'(ADV_MAX));

  // R6
  vlen_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.vlen >= LEN_W'(VLEN_MIN));

endmodule

bind scan_blank_gen bg_chk u_bg_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hblank  (hblank_o),
  .vblank  (vblank_o),
  .sync_ok (sync_ok_o),
  .hfly_q  (hfly_q),
  .vst_q   (vst_q),
  .act     (act_cfg)
);

// File: tb/test_scan_blank_gen.sv
module test_scan_blank_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CLKS  = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hfly_i, vstrb_i, cfg_wr_i;
  logic [6:0]  cfg_vlen_i, cfg_adv_i;
  logic [2:0]  cfg_ppl_i;
  logic        cfg_hen_i, cfg_ven_i;
  logic [10:0] cfg_vto_i;
  logic        hblank_o, vblank_o, sync_ok_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_blank_gen i_scan_blank_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .hfly_i     (hfly_i),
    .vstrb_i    (vstrb_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_vlen_i (cfg_vlen_i),
    .cfg_adv_i  (cfg_adv_i),
    .cfg_ppl_i  (cfg_ppl_i),
    .cfg_hen_i  (cfg_hen_i),
    .cfg_ven_i  (cfg_ven_i),
    .cfg_vto_i  (cfg_vto_i),
    .hblank_o   (hblank_o),
    .vblank_o   (vblank_o),
    .sync_ok_o  (sync_ok_o)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic write_cfg(input int vlen, input int adv, input int code,
                           input bit hen, input bit ven, input int vto);
    cfg_vlen_i = 7'(vlen);
    cfg_adv_i  = 7'(adv);
    cfg_ppl_i  = 3'(code);
    cfg_hen_i  = hen;
    cfg_ven_i  = ven;
    cfg_vto_i  = 11'(vto);
    cfg_wr_i   = 1'b1;
    @(negedge clk);
    cfg_wr_i   = 1'b0;
    @(negedge clk);
  endtask

  task automatic vstart();
    vstrb_i = 1'b1;
    @(negedge clk);
    vstrb_i = 1'b0;
  endtask

  task automatic fly(input int w, input int gap);
    hfly_i = 1'b1;
    repeat (w) @(negedge clk);
    hfly_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // flyback raised at k=0; checks at negedge k (after edge k-1 since the rise)
  task automatic line_chk(input int w, input int lo, input int hi, input string req);
    hfly_i = 1'b1;
    for (int k = 1; k <= hi; k++) begin
      @(negedge clk);
      if (k == 1)      chk(hblank_o, 1'b1, "R3", "open on flyback");
      if (k == w)      chk(hblank_o, 1'b1, "R3", "held during flyback");
      if (k == w + 1)  chk(hblank_o, 1'b0, "R3", "closed after flyback");
      if (k == lo)     chk(hblank_o, 1'b0, req, "before early start");
      if (k == hi)     chk(hblank_o, 1'b1, req, "early start");
      if (k == w)      hfly_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(hblank_o,  1'b0, "R1", "hblank after reset");
    chk(vblank_o,  1'b0, "R1", "vblank after reset");
    chk(sync_ok_o, 1'b0, "R1", "sync_ok after reset");
  endtask

  task automatic t_no_early();
    logic seen_hi = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (hblank_o) seen_hi = 1'b1;
    end
    chk(seen_hi, 1'b0, "R5", "no blanking before first flyback");
  endtask

  task automatic t_sync_valid();
    fly(2, 4);
    chk(sync_ok_o, 1'b0, "R9", "flyback alone");
    vstart();
    chk(sync_ok_o, 1'b1, "R9", "flyback and vertical strobe");
    repeat (3) fly(2, 4);
  endtask

  task automatic t_vlen(input bit do_wr, input int prog, input string req);
    int n;
    n = (prog < 3) ? 3 : prog;
    if (do_wr) write_cfg(prog, 0, 0, 1, 1, 0);
    vstart();
    chk(vblank_o, 1'b1, req, "vblank opens");
    for (int i = 1; i <= n; i++) begin
      fly(2, 6);
      if (i == n - 1) chk(vblank_o, 1'b1, req, "vblank before last line");
      if (i == n)     chk(vblank_o, 1'b0, req, "vblank closes on last line");
    end
  endtask

  task automatic t_early(input int code, input int adv, input string req);
    int ppl, a, lo;
    ppl = 704 + 64 * code;
    a   = (adv > 64) ? 64 : adv;
    lo  = ppl - a;
    write_cfg(3, adv, code, 1, 1, 0);
    vstart();
    fly(3, 3);
    line_chk(8, lo, lo + 1, req);
    fly(3, 3);
  endtask

  task automatic t_enable();
    write_cfg(3, 0, 0, 0, 1, 0);
    hfly_i = 1'b1;
    @(negedge clk);
    chk(hblank_o, 1'b1, "R8", "hen write not yet loaded");
    hfly_i = 1'b0;
    repeat (3) @(negedge clk);
    vstart();
    hfly_i = 1'b1;
    @(negedge clk);
    chk(hblank_o, 1'b0, "R7", "hblank held low when disabled");
    hfly_i = 1'b0;
    repeat (3) @(negedge clk);
    repeat (3) fly(2, 4);
    write_cfg(3, 0, 0, 1, 0, 0);
    vstart();
    chk(vblank_o, 1'b0, "R7", "vblank held low when disabled");
    hfly_i = 1'b1;
    @(negedge clk);
    chk(hblank_o, 1'b1, "R8", "hen reload at vertical start");
    hfly_i = 1'b0;
    repeat (3) @(negedge clk);
    write_cfg(3, 0, 0, 1, 1, 0);
    vstart();
    repeat (3) fly(2, 4);
  endtask

  task automatic t_h_timeout();
    fly(2, 4);
    vstart();
    hfly_i = 1'b1;
    for (int k = 1; k <= 2305; k++) begin
      @(negedge clk);
      if (k == 2)    hfly_i = 1'b0;
      if (k == 2304) chk(sync_ok_o, 1'b1, "R10", "sync just before timeout");
      if (k == 2305) chk(sync_ok_o, 1'b0, "R10", "sync after flyback timeout");
    end
    fly(2, 2);
    chk(sync_ok_o, 1'b1, "R10", "sync back on flyback");
  endtask

  task automatic t_v_timeout();
    write_cfg(3, 0, 0, 1, 1, 4);
    fly(2, 4);
    vstart();
    for (int i = 1; i <= 4; i++) begin
      fly(2, 4);
      if (i == 3) chk(sync_ok_o, 1'b1, "R11", "sync before line timeout");
      if (i == 4) chk(sync_ok_o, 1'b0, "R11", "sync after line timeout");
    end
    write_cfg(3, 0, 0, 1, 1, 0);
    vstart();
    chk(sync_ok_o, 1'b1, "R11", "sync back on vertical strobe");
    repeat (6) fly(2, 4);
    chk(sync_ok_o, 1'b1, "R11", "timeout 0 disabled");
  endtask

  initial begin
    rst_n = 1'b0;
    hfly_i = 1'b0; vstrb_i = 1'b0; cfg_wr_i = 1'b0;
    cfg_vlen_i = '0; cfg_adv_i = '0; cfg_ppl_i = '0;
    cfg_hen_i = 1'b1; cfg_ven_i = 1'b1; cfg_vto_i = '0;
    repeat (3) @(negedge clk);
    chk(hblank_o, 1'b0, "R1", "hblank in reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_early();
    t_sync_valid();
    t_vlen(1'b0, 3, "R1/R6 default length");
    t_vlen(1'b1, 1, "R6 below minimum");
    t_vlen(1'b1, 5, "R6 middle");
    t_vlen(1'b1, 127, "R6 maximum");
    t_early(0, 10, "R2/R4 code0");
    t_early(3, 5, "R2/R4 code3");
    t_early(7, 32, "R2/R4 code7");
    t_early(0, 100, "R4 clamp");
    t_enable();
    t_h_timeout();
    t_v_timeout();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WDOG_CLKS) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule